// File: doc/BRIEF.md
# Multiplexed-Bus Memory Select and Read Path

This block sits between an 8-bit processor whose low address byte and data share one bus and the program and data memories behind it. While the address-latch strobe is high it captures the low address byte from the shared bus on every clock. While the strobe is low it holds that byte and joins it to the separately driven high address byte to form a 16-bit address.

The address is decoded into three active-low chip enables: a 4 KB program ROM window at 0x0000, a second 4 KB program ROM window at 0x4000, and a 2 KB RAM window at 0x2000. Every other address leaves all enables high. The memory output enable follows the active-low read strobe. The shared bus is split into an input byte, an output byte and an output-enable pin, so that the released bus state can be seen directly. Stand-in memory contents are computed from the in-window offset. They are returned on the bus only while a read is in progress and a window is selected. After reset the captured byte is zero. With the high byte at zero, the first fetch address 0x0000 therefore selects the first ROM window.

Top module: `muxbus_memsel`

## Requirements
- R1: On each rising clock edge with `ale` high, the low address byte is loaded from `ad_i`. While `ale` is low it is held, and changes on `ad_i` affect no output.
- R2: `ce_rom0_n` is low exactly for addresses 0x0000 to 0x0FFF.
- R3: `ce_rom1_n` is low exactly for addresses 0x4000 to 0x4FFF.
- R4: `ce_ram_n` is low exactly for addresses 0x2000 to 0x27FF, that is, when bits 15:11 equal 00100.
- R5: At most one chip enable is low for any address, and none is low outside the three windows.
- R6: `oe_n` equals `rd_n` in every cycle.
- R7: `ad_oe` is 1 only while `rd_n` is 0 and some chip enable is low. Otherwise it is 0, which means the bus is released.
- R8: While `ad_oe` is 1, `ad_o` carries the window's byte for offset `o`. The first ROM window gives o[7:0] XOR {o[11:8],o[11:8]}, using offset bits 11:0. The second ROM window gives NOT o[7:0] XOR {4'h0,o[11:8]}, using offset bits 11:0. The RAM window gives (o[7:0] XOR 8'h5A) + o[10:8], using offset bits 10:0.
- R9: After reset the captured low byte is 0x00. With `a_hi` at 0x00 this selects the first ROM window, and the other enables and `ad_oe` stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address-latch strobe, high during address phase |
| rd_n | input | 1 | Active-low read strobe |
| a_hi | input | 8 | High address byte |
| ad_i | input | 8 | Shared bus as driven by the processor |
| ad_o | output | 8 | Read data toward the shared bus |
| ad_oe | output | 1 | Drive enable for ad_o; 0 releases the bus |
| ce_rom0_n | output | 1 | First ROM window enable, active low |
| ce_rom1_n | output | 1 | Second ROM window enable, active low |
| ce_ram_n | output | 1 | RAM window enable, active low |
| oe_n | output | 1 | Memory output enable, active low |

## Verification
The low-byte register is the only clocked element. Enables and read data therefore depend on the edge that ends the address phase. After that edge they follow `a_hi` and `rd_n` with no further delay. The bench applies each address at a falling edge with `ale` high. It drops `ale` and `rd_n` at the next falling edge and compares against its reference model shortly after. One clock later it scrambles `ad_i` and compares again, which tests the hold behaviour. It then raises `rd_n` and checks within the same half cycle that the bus has been released.

// File: rtl/muxbus_memsel.sv
module muxbus_memsel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic       rd_n,
  input  logic [7:0] a_hi,
  input  logic [7:0] ad_i,
  output logic [7:0] ad_o,
  output logic       ad_oe,
  output logic       ce_rom0_n,
  output logic       ce_rom1_n,
  output logic       ce_ram_n,
  output logic       oe_n
);

  localparam logic [3:0] ROM0_TAG = 4'h0;
  localparam logic [3:0] ROM1_TAG = 4'h4;
  localparam logic [4:0] RAM_TAG  = 5'b00100;

  logic [7:0]  lat;
  logic [15:0] addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   lat <= 8'h00;
    else if (ale) lat <= ad_i;

  assign addr = {a_hi, lat};

  assign ce_rom0_n = !(addr[15:12] == ROM0_TAG);
  assign ce_rom1_n = !(addr[15:12] == ROM1_TAG);
  assign ce_ram_n  = !(addr[15:11] == RAM_TAG);
  assign oe_n      = rd_n;

  function automatic logic [7:0] rom0_byte(input logic [11:0] o);
    return o[7:0] ^ {o[11:8], o[11:8]};
  endfunction

  function automatic logic [7:0] rom1_byte(input logic [11:0] o);
    return ~o[7:0] ^ {4'h0, o[11:8]};
  endfunction

  function automatic logic [7:0] ram_byte(input logic [10:0] o);
    return (o[7:0] ^ 8'h5A) + {5'b0, o[10:8]};
  endfunction

  always_comb begin
    ad_o = 8'h00;
    if (!ce_rom0_n)      ad_o = rom0_byte(addr[11:0]);
    else if (!ce_rom1_n) ad_o = rom1_byte(addr[11:0]);
    else if (!ce_ram_n)  ad_o = ram_byte(addr[10:0]);
  end

  assign ad_oe = !rd_n && !(ce_rom0_n && ce_rom1_n && ce_ram_n);

endmodule

module muxbus_memsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic [7:0] a_hi,
  input logic [7:0] lat,
  input logic       ad_oe,
  input logic       ce_rom0_n,
  input logic       ce_rom1_n,
  input logic       ce_ram_n,
  input logic       oe_n
);

  a_r1_hold_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(lat));

  a_r2_rom0_window: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_rom0_n |-> a_hi[7:4] == 4'h0);

  a_r3_rom1_window: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_rom1_n |-> a_hi[7:4] == 4'h4);

  a_r4_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_ram_n |-> a_hi[7:3] == 5'b00100);

  a_r5_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ce_rom0_n, ~ce_rom1_n, ~ce_ram_n}) <= 1);

  a_r6_oe_tracks_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> oe_n);

  a_r7_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!rd_n && !(ce_rom0_n && ce_rom1_n && ce_ram_n)));

endmodule

bind muxbus_memsel muxbus_memsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .a_hi(a_hi),
  .lat(lat), .ad_oe(ad_oe), .ce_rom0_n(ce_rom0_n),
  .ce_rom1_n(ce_rom1_n), .ce_ram_n(ce_ram_n), .oe_n(oe_n)
);

// File: tb/muxbus_memsel_bench.sv
module muxbus_memsel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic       rd_n = 1'b1;
  logic [7:0] a_hi = 8'h00;
  logic [7:0] ad_i = 8'h00;
  logic [7:0] ad_o;
  logic       ad_oe, ce_rom0_n, ce_rom1_n, ce_ram_n, oe_n;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  muxbus_memsel u_muxbus_memsel (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .a_hi(a_hi),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .ce_rom0_n(ce_rom0_n),
    .ce_rom1_n(ce_rom1_n), .ce_ram_n(ce_ram_n), .oe_n(oe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model: region 0 none, 1 rom0, 2 rom1, 3 ram
  function automatic int region(input int a);
    if (a >= 'h0000 && a <= 'h0FFF) return 1;
    if (a >= 'h4000 && a <= 'h4FFF) return 2;
    if (a >= 'h2000 && a <= 'h27FF) return 3;
    return 0;
  endfunction

  function automatic int model_data(input int a);
    int o;
    case (region(a))
      1: begin o = a % 4096; return ((o % 256) ^ ((o / 256) * 17)) & 255; end
      2: begin o = a % 4096; return (255 - (o % 256)) ^ (o / 256); end
      3: begin o = a % 2048; return (((o % 256) ^ 'h5A) + (o / 256)) & 255; end
      default: return 0;
    endcase
  endfunction

  task automatic compare_all(input int a, input bit reading, input string when);
    int r = region(a);
    check({"R2 ", when}, int'(ce_rom0_n), (r == 1) ? 0 : 1);
    check({"R3 ", when}, int'(ce_rom1_n), (r == 2) ? 0 : 1);
    check({"R4 ", when}, int'(ce_ram_n),  (r == 3) ? 0 : 1);
    check({"R5 ", when}, 3 - (ce_rom0_n + ce_rom1_n + ce_ram_n), (r == 0) ? 0 : 1);
    check({"R6 ", when}, int'(oe_n), reading ? 0 : 1);
    check({"R7 ", when}, int'(ad_oe), (reading && r != 0) ? 1 : 0);
    if (reading && r != 0) check({"R8 ", when}, int'(ad_o), model_data(a));
  endtask

  task automatic access(input int a);
    @(negedge clk);
    ale = 1'b1; rd_n = 1'b1;
    a_hi = 8'(a / 256); ad_i = 8'(a % 256);
    @(negedge clk);
    ale = 1'b0; rd_n = 1'b0;
    #1 compare_all(a, 1'b1, "read");
    @(negedge clk);
    ad_i = ~ad_i;
    #1 compare_all(a, 1'b1, "R1 hold");
    rd_n = 1'b1;
    #1 compare_all(a, 1'b0, "idle");
  endtask

  initial begin
    int edges [10] = '{'h0FFF, 'h1000, 'h1FFF, 'h2000, 'h27FF,
                       'h2800, 'h3FFF, 'h4000, 'h4FFF, 'h5000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset rom0", int'(ce_rom0_n), 0);
    check("R9 reset others", int'({ce_rom1_n, ce_ram_n}), 3);
    check("R9 reset bus", int'(ad_oe), 0);
    foreach (edges[i]) access(edges[i]);
    access('h0000);
    access('h0ABC);
    access('h4321);
    access('h2345);
    access('hFFFF);
    for (int h = 0; h < 256; h++) access(h * 256 + (h ^ 'hA5));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        vectors++; misses++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule